// File: doc/BRIEF.md
# Retriggerable Programmable Down Timer

This block is a 16-bit interval timer that sits behind a simple register bus. Software writes a start value and the counter then steps down by one on every cycle in which the tick-enable input is high. The tick-enable comes from a fixed-rate master clock divider outside the block. When the count steps below zero, the block raises a single-cycle interrupt pulse. It then stops and holds all ones until software loads it again.

A new nonzero write at any moment reloads the counter and restarts the countdown, so software can keep postponing expiry by rewriting it. A zero start value is illegal and the block ignores it. The live count can be read back at any time through the read strobe. A loaded value N therefore expires after N+1 ticks.

Top module: `dtmr_retrig`

## Requirements
- R1: While running, each cycle with `tick_en` high and no valid write lowers the count by one.
- R2: A write with nonzero `wr_data` loads that value on the next edge and starts the countdown. The write itself raises no interrupt.
- R3: A tick taken at count 0 sets the count to 0xFFFF and stops the counter. Later ticks leave 0xFFFF unchanged.
- R4: `irq` is high for exactly one cycle, in the cycle after the edge that took the tick at count 0. A load of N gives `irq` after the (N+1)th tick.
- R5: A write with `wr_data` of zero is ignored. The count and the running state are unchanged by it, a tick in the same cycle still applies, and no interrupt results.
- R6: After reset the count is 0xFFFF, the counter is idle and `irq` is low. Ticks have no effect until the first valid write.
- R7: When a valid write and a tick fall in the same cycle, the written value is loaded and that tick is dropped.
- R8: `rd_data` shows the current count while `rd_en` is high, and reads as zero while `rd_en` is low.
- R9: A valid write issued before expiry restarts the countdown from the new value, and no interrupt comes from the old interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle master tick enable |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Start value to load |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Current count while reading, else zero |
| irq | output | 1 | One-cycle expiry pulse |

## Verification
A counter that skips or repeats a step moves the expiry pulse off the N+1 tick mark. It also makes the very next read disagree with the expected count, one cycle after the faulty edge. A lost running flag shows up in one of two ways. Either a parked 0xFFFF moves under later ticks, or a counter that should be running sits still. Either case is visible on the first read after it happens. Priority or zero-write faults change the count on the edge of the offending cycle, so a read held high across that edge exposes them at once.

// File: rtl/dtmr_retrig.sv
module dtmr_retrig #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         irq
);
  localparam logic [W-1:0] PARK = '1;

  logic [W-1:0] cnt;
  logic         run;
  logic         load;
  logic         step;
  logic         expire;

  assign load   = wr_en && (wr_data != '0);
  assign step   = tick_en && run && !load;
  assign expire = step && (cnt == '0);
  assign rd_data = rd_en ? cnt : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= PARK;
      run <= 1'b0;
      irq <= 1'b0;
    end else begin
      irq <= expire;
      if (load) begin
        cnt <= wr_data;
        run <= 1'b1;
      end else if (step) begin
        cnt <= cnt - 1'b1;
        if (cnt == '0) run <= 1'b0;
      end
    end
  end

  p_dec_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run && tick_en && !wr_en && cnt != '0 |=> cnt == $past(cnt) - 1'b1);
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data != '0 |=> cnt == $past(wr_data) && !irq);
  p_park_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cnt == PARK && !run);
  p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data == '0 && !tick_en |=> $stable(cnt) && !irq);
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> cnt == PARK);
  p_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == '0);
endmodule

// File: tb/sim_dtmr_retrig.sv
`timescale 1ns/1ps
module sim_dtmr_retrig;
  logic clk = 0, rst_n = 0, tick_en = 0, wr_en = 0, rd_en = 0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] m_cnt = 16'hFFFF;
  logic m_run = 0, m_irq = 0;

  always #2.5 clk = ~clk;

  dtmr_retrig u0 (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq));

  function automatic logic [16:0] next_state(logic [15:0] c, logic r, logic t,
                                             logic w, logic [15:0] d);
    if (w && d != 0) return {1'b1, d};
    if (t && r) return (c == 0) ? {1'b0, 16'hFFFF} : {1'b1, c - 16'd1};
    return {r, c};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(logic t, logic w, logic [15:0] d, logic rd, string tag);
    logic [16:0] ns;
    @(negedge clk);
    tick_en = t; wr_en = w; wr_data = d; rd_en = rd;
    @(posedge clk);
    m_irq = t && m_run && !(w && d != 0) && m_cnt == 0;
    ns = next_state(m_cnt, m_run, t, w, d);
    m_run = ns[16]; m_cnt = ns[15:0];
    #1;
    chk({tag, " irq"}, {31'd0, irq}, {31'd0, m_irq});
    chk({tag, " rd"}, {16'd0, rd_data}, {16'd0, rd ? m_cnt : 16'd0});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R6: reset state, ticks ignored while idle
    step(0, 0, 0, 1, "R6 reset");
    step(1, 0, 0, 1, "R6 idle tick");
    step(1, 0, 0, 1, "R6 idle tick2");
    // R2, R1, R4, R3: load 3, expire after 4 ticks
    step(0, 1, 16'd3, 1, "R2 load");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 1, "R1 dec");
    step(1, 0, 0, 1, "R4 expire");
    chk("R4 pulse", {31'd0, irq}, 32'd1);
    step(0, 0, 0, 1, "R4 one cycle");
    chk("R4 low", {31'd0, irq}, 32'd0);
    step(1, 0, 0, 1, "R3 parked");
    chk("R3 park", {16'd0, rd_data}, 32'h0000FFFF);
    // R9: retrigger before expiry
    step(0, 1, 16'd2, 1, "R9 load");
    step(1, 0, 0, 1, "R9 dec");
    step(0, 1, 16'd5, 1, "R9 retrig");
    chk("R9 value", {16'd0, rd_data}, 32'd5);
    // R7: write and tick same cycle
    step(1, 1, 16'd9, 1, "R7 prio");
    chk("R7 value", {16'd0, rd_data}, 32'd9);
    // R5: zero write ignored, tick still applies
    step(0, 1, 16'd0, 1, "R5 zero");
    chk("R5 hold", {16'd0, rd_data}, 32'd9);
    step(1, 1, 16'd0, 1, "R5 zero tick");
    chk("R5 tick", {16'd0, rd_data}, 32'd8);
    // R8: read strobe low gives zero
    step(0, 0, 0, 0, "R8 no read");
    chk("R8 zero", {16'd0, rd_data}, 32'd0);
    // load 1: expires after 2 ticks
    step(0, 1, 16'd1, 1, "R4 load1");
    step(1, 0, 0, 1, "R4 t1");
    step(1, 0, 0, 1, "R4 t2");
    chk("R4 load1 pulse", {31'd0, irq}, 32'd1);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic w = ($urandom % 12) == 0;
      logic [15:0] d = ($urandom % 5 == 0) ? 16'd0 : 16'($urandom % 24);
      step(1'($urandom % 3 != 0), w, d, 1'($urandom % 4 != 0), "R1 random");
    end
    finish_run();
  end
endmodule